// File: doc/BRIEF.md
# Two-Stage Complex Multiply-Accumulate Arithmetic Unit

This block is the number-crunching core of a vector datapath. Each clock it can accept one pair of signed complex operands, B and C, arriving from two read ports already aligned and formatted. It delivers one complex result per clock toward a write port. The block does no formatting, shifting, scaling or rounding. It holds no status flags. Every value is kept at full precision and wraps only at the accumulator width.

The work is split across two registered stages, and each stage has its own opcode. The front stage holds the multiplier and a general ALU. It applies one function to B and C in one of three ways: as complex numbers, as two independent scalar lanes (one function on the real parts and another on the imaginary parts), or by folding the real and imaginary parts of B into each other. The back stage combines the front-stage result with a per-component accumulator. A multiply in the front stage followed by an accumulating add in the back stage gives a running sum of products over a stream, one product per beat. A clear input restarts the sum without a bubble.

Top module: `cau_top`

## Requirements
- R1: While reset is asserted, at the first clock edge, res_valid, res_re, res_im and both accumulator components are driven to zero.
- R2: res_valid is high exactly two clock edges after a beat is sampled with in_valid high, and is low otherwise. The block accepts one beat per clock with no stalls.
- R3: up_mode is 0 (complex) or 3 (same as 0). In these modes up_op applies to each component: 0 add B+C, 1 subtract B−C, 4 signed maximum, 5 signed minimum, 15 pass B. Results are sign-extended to the 40-bit result width.
- R4: In complex mode, up_op 2 gives the full-precision complex product B·C. up_op 3 gives B·conj(C), which has real part br·cr+bi·ci and imaginary part bi·cr−br·ci. Neither result is truncated.
- R5: Compares are up_op 6 equal, 7 less, 8 greater, 9 less-or-equal and 10 greater-or-equal, all signed. Each gives 1 or 0 in the real part and 0 in the imaginary part. In complex mode, equal needs both parts equal, and the ordering compares use the real parts only.
- R6: up_op 11 AND, 12 NAND, 13 OR and 14 NOR work bitwise on the 16-bit operands. The 16-bit result is then sign-extended.
- R7: With up_mode 1 (split), the real result is up_op applied to (B.re, C.re). The imaginary result is up_op2 applied to (B.im, C.im). Multiply codes are then the plain scalar product.
- R8: With up_mode 2 (combine), the real result is up_op applied to (B.re, B.im). The imaginary result is zero and C has no effect.
- R9: lo_op 0 (pass) outputs the front-stage result and leaves the accumulator unchanged.
- R10: lo_op 1 sets the accumulator to acc+u, lo_op 2 sets it to acc−u, and lo_op 3 sets it to the signed maximum of acc and u, per component. Each wraps modulo 2^40, and the new accumulator value is the output.
- R11: If acc_clear is high on a beat whose lo_op is nonzero, that beat's front-stage result is loaded into the accumulator unchanged, and the prior contents are ignored.
- R12: A cycle in which the back stage holds no valid beat leaves the accumulator, res_re and res_im unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand beat present this cycle |
| b_re | input | 16 | Operand B real part, signed |
| b_im | input | 16 | Operand B imaginary part, signed |
| c_re | input | 16 | Operand C real part, signed |
| c_im | input | 16 | Operand C imaginary part, signed |
| up_mode | input | 2 | Front-stage mode: 0/3 complex, 1 split, 2 combine |
| up_op | input | 4 | Front-stage function code |
| up_op2 | input | 4 | Imaginary-lane function code in split mode |
| lo_op | input | 2 | Back-stage function: 0 pass, 1 add, 2 subtract, 3 maximum |
| acc_clear | input | 1 | Load this beat's front-stage result into the accumulator |
| res_valid | output | 1 | Result present |
| res_re | output | 40 | Result real part, signed |
| res_im | output | 40 | Result imaginary part, signed |

## Verification
Every result is due on the second rising edge after its operands are sampled. The front stage registers at the first edge, and the result register and accumulator update together at the second. The bench drives each beat at a falling edge. It advances a two-register reference pipeline for the coming edge, and it compares res_valid, res_re and res_im at the next falling edge against the reference output register. This keeps each comparison exactly two edges behind the beat that produced it. Bubble cycles are compared against the held value. Accumulator state can only be seen through later accumulating beats, so the directed sequences follow each clear, pass and bubble with an accumulating beat.

// File: rtl/cau_pkg.sv
`timescale 1ns/1ps
// Shared codes for the two-stage complex arithmetic unit.
// Assumes 4-bit front-stage and 2-bit back-stage function fields.
package cau_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_MUL  = 4'd2,
        OP_CMUL = 4'd3,
        OP_MAX  = 4'd4,
        OP_MIN  = 4'd5,
        OP_EQ   = 4'd6,
        OP_LT   = 4'd7,
        OP_GT   = 4'd8,
        OP_LE   = 4'd9,
        OP_GE   = 4'd10,
        OP_AND  = 4'd11,
        OP_NAND = 4'd12,
        OP_OR   = 4'd13,
        OP_NOR  = 4'd14,
        OP_PASS = 4'd15
    } up_op_e;

    typedef enum logic [1:0] {
        MODE_CPLX  = 2'd0,
        MODE_SPLIT = 2'd1,
        MODE_COMB  = 2'd2,
        MODE_CPLX2 = 2'd3
    } up_mode_e;

    typedef enum logic [1:0] {
        LO_PASS = 2'd0,
        LO_ADD  = 2'd1,
        LO_SUB  = 2'd2,
        LO_MAX  = 2'd3
    } lo_op_e;

    // True for the five compare codes.
    function automatic logic is_cmp(input logic [3:0] op);
        return (op >= 4'd6) && (op <= 4'd10);
    endfunction

endpackage

// File: rtl/cau_lane.sv
`timescale 1ns/1ps
// Scalar function lane: applies one front-stage function code to two
// signed DW-bit values and returns a sign-extended AW-bit result.
// Purely combinational. Assumes AW > 2*DW so that products fit.
module cau_lane
    import cau_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [3:0]    op,
    output logic [AW-1:0] y
);
    localparam int PW = 2 * DW;

    up_op_e               opc;
    logic signed [DW-1:0] sa;
    logic signed [DW-1:0] sb;
    logic signed [PW-1:0] prod;
    logic [AW-1:0]        ea;
    logic [AW-1:0]        eb;
    logic [AW-1:0]        eprod;
    logic [DW-1:0]        lg;
    logic [AW-1:0]        elg;

    assign opc   = up_op_e'(op);
    assign sa    = $signed(a);
    assign sb    = $signed(b);
    assign prod  = sa * sb;
    assign ea    = {{(AW-DW){a[DW-1]}}, a};
    assign eb    = {{(AW-DW){b[DW-1]}}, b};
    assign eprod = {{(AW-PW){prod[PW-1]}}, prod};
    assign elg   = {{(AW-DW){lg[DW-1]}}, lg};

    // Bitwise logic result on the narrow operands.
    always_comb begin
        case (opc)
            OP_AND:  lg = a & b;
            OP_NAND: lg = ~(a & b);
            OP_OR:   lg = a | b;
            OP_NOR:  lg = ~(a | b);
            default: lg = a;
        endcase
    end

    // Function select for the lane.
    always_comb begin
        y = '0;
        case (opc)
            OP_ADD:  y = ea + eb;
            OP_SUB:  y = ea - eb;
            OP_MUL,
            OP_CMUL: y = eprod;
            OP_MAX:  y = (sa > sb) ? ea : eb;
            OP_MIN:  y = (sa < sb) ? ea : eb;
            OP_EQ:   y[0] = (sa == sb);
            OP_LT:   y[0] = (sa < sb);
            OP_GT:   y[0] = (sa > sb);
            OP_LE:   y[0] = (sa <= sb);
            OP_GE:   y[0] = (sa >= sb);
            OP_AND,
            OP_NAND,
            OP_OR,
            OP_NOR:  y = elg;
            default: y = ea;
        endcase
    end

endmodule

// File: rtl/cau_upper.sv
`timescale 1ns/1ps
// Front stage: multiplier plus ALU over complex operands B and C.
// Two scalar lanes serve split and combine modes. Complex mode overrides
// them for the complex products and the compares. The result, the
// back-stage code and the clear flag are registered together with valid.
// Assumes the operands are already aligned signed values.
module cau_upper
    import cau_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] b_re,
    input  logic [DW-1:0] b_im,
    input  logic [DW-1:0] c_re,
    input  logic [DW-1:0] c_im,
    input  logic [1:0]    mode,
    input  logic [3:0]    op,
    input  logic [3:0]    op2,
    input  logic [1:0]    lo_op,
    input  logic          clr,
    output logic          s1_valid,
    output logic [AW-1:0] s1_re,
    output logic [AW-1:0] s1_im,
    output logic [1:0]    s1_lo_op,
    output logic          s1_clr
);
    localparam int PW    = 2 * DW;
    localparam int LANES = 2;

    logic [DW-1:0] lane_a  [LANES];
    logic [DW-1:0] lane_b  [LANES];
    logic [3:0]    lane_op [LANES];
    logic [AW-1:0] lane_y  [LANES];

    logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir;
    logic [AW-1:0] e_rr, e_ii, e_ri, e_ir;
    logic [AW-1:0] nxt_re, nxt_im;
    logic          cplx;

    assign cplx = (mode != MODE_SPLIT) && (mode != MODE_COMB);

    // Lane operand routing: combine folds B's parts; split takes op2 for the imaginary lane.
    always_comb begin
        lane_a[0]  = b_re;
        lane_b[0]  = (mode == MODE_COMB) ? b_im : c_re;
        lane_op[0] = op;
        lane_a[1]  = b_im;
        lane_b[1]  = c_im;
        lane_op[1] = (mode == MODE_SPLIT) ? op2 : op;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        cau_lane #(.DW(DW), .AW(AW)) u_lane (
            .a  (lane_a[g]),
            .b  (lane_b[g]),
            .op (lane_op[g]),
            .y  (lane_y[g])
        );
    end

    assign p_rr = $signed(b_re) * $signed(c_re);
    assign p_ii = $signed(b_im) * $signed(c_im);
    assign p_ri = $signed(b_re) * $signed(c_im);
    assign p_ir = $signed(b_im) * $signed(c_re);
    assign e_rr = {{(AW-PW){p_rr[PW-1]}}, p_rr};
    assign e_ii = {{(AW-PW){p_ii[PW-1]}}, p_ii};
    assign e_ri = {{(AW-PW){p_ri[PW-1]}}, p_ri};
    assign e_ir = {{(AW-PW){p_ir[PW-1]}}, p_ir};

    // Result select: lane outputs, with complex-mode overrides.
    always_comb begin
        nxt_re = lane_y[0];
        nxt_im = lane_y[1];
        if (mode == MODE_COMB) begin
            nxt_im = '0;
        end else if (cplx) begin
            if (op == OP_MUL) begin
                nxt_re = e_rr - e_ii;
                nxt_im = e_ri + e_ir;
            end else if (op == OP_CMUL) begin
                nxt_re = e_rr + e_ii;
                nxt_im = e_ir - e_ri;
            end else if (is_cmp(op)) begin
                nxt_im = '0;
                if (op == OP_EQ) begin
                    nxt_re    = '0;
                    nxt_re[0] = lane_y[0][0] & lane_y[1][0];
                end
            end
        end
    end

    // Stage register: valid always advances, payload only on a valid beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_re    <= '0;
            s1_im    <= '0;
            s1_lo_op <= '0;
            s1_clr   <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_re    <= nxt_re;
                s1_im    <= nxt_im;
                s1_lo_op <= lo_op;
                s1_clr   <= clr;
            end
        end
    end

    // A compare outside split mode yields a 0/1 real part and a zero imaginary part.
    assert_cmp_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (mode != MODE_SPLIT) && is_cmp(op))
            |=> ((s1_re[AW-1:1] == '0) && (s1_im == '0)));

    // Combine mode never produces an imaginary part.
    assert_comb_im_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (mode == MODE_COMB)) |=> (s1_im == '0));

endmodule

// File: rtl/cau_lower.sv
`timescale 1ns/1ps
// Back stage: combines the front-stage result with a per-component
// accumulator. The accumulator and result register change only on a valid
// beat. A clear flag loads the incoming value in place of the old sum.
// Arithmetic wraps at AW bits.
module cau_lower
    import cau_pkg::*;
#(
    parameter int AW = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s1_valid,
    input  logic [AW-1:0] u_re,
    input  logic [AW-1:0] u_im,
    input  logic [1:0]    lo_op,
    input  logic          clr,
    output logic          res_valid,
    output logic [AW-1:0] res_re,
    output logic [AW-1:0] res_im
);
    localparam int NCOMP = 2;

    logic [NCOMP-1:0][AW-1:0] u_v;
    logic [NCOMP-1:0][AW-1:0] acc_q;
    logic [NCOMP-1:0][AW-1:0] acc_n;
    logic [NCOMP-1:0][AW-1:0] out_n;
    logic [NCOMP-1:0][AW-1:0] res_q;

    assign u_v[0] = u_re;
    assign u_v[1] = u_im;

    for (genvar g = 0; g < NCOMP; g++) begin : g_comp
        // Per-component accumulate function.
        always_comb begin
            acc_n[g] = acc_q[g];
            out_n[g] = u_v[g];
            case (lo_op_e'(lo_op))
                LO_ADD:  acc_n[g] = clr ? u_v[g] : acc_q[g] + u_v[g];
                LO_SUB:  acc_n[g] = clr ? u_v[g] : acc_q[g] - u_v[g];
                LO_MAX:  acc_n[g] = (clr || ($signed(u_v[g]) > $signed(acc_q[g])))
                                    ? u_v[g] : acc_q[g];
                default: acc_n[g] = acc_q[g];
            endcase
            if (lo_op != LO_PASS) begin
                out_n[g] = acc_n[g];
            end
        end
    end

    // Accumulator and result registers, updated on valid beats only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            acc_q     <= '0;
            res_q     <= '0;
        end else begin
            res_valid <= s1_valid;
            if (s1_valid) begin
                acc_q <= acc_n;
                res_q <= out_n;
            end
        end
    end

    assign res_re = res_q[0];
    assign res_im = res_q[1];

    // Empty back-stage cycles hold both accumulator and result.
    assert_bubble_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!s1_valid) |=> ($stable(acc_q) && $stable(res_q)));

    // Pass beats leave the accumulator alone and forward the front result.
    assert_pass_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && (lo_op == LO_PASS))
            |=> ($stable(acc_q) && (res_q == $past({u_im, u_re}))));

    // A clear on an accumulating beat loads the incoming value.
    assert_clear_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && clr && (lo_op != LO_PASS))
            |=> (acc_q == $past({u_im, u_re})));

endmodule

// File: rtl/cau_top.sv
`timescale 1ns/1ps
// Two-stage complex arithmetic unit: front stage (multiplier + ALU) feeds
// the back stage (ALU + accumulator). One beat in, one result out per
// clock, two edges of latency. Operands arrive pre-formatted.
module cau_top #(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] b_re,
    input  logic [DW-1:0] b_im,
    input  logic [DW-1:0] c_re,
    input  logic [DW-1:0] c_im,
    input  logic [1:0]    up_mode,
    input  logic [3:0]    up_op,
    input  logic [3:0]    up_op2,
    input  logic [1:0]    lo_op,
    input  logic          acc_clear,
    output logic          res_valid,
    output logic [AW-1:0] res_re,
    output logic [AW-1:0] res_im
);
    logic          s1_valid;
    logic [AW-1:0] s1_re;
    logic [AW-1:0] s1_im;
    logic [1:0]    s1_lo_op;
    logic          s1_clr;
    logic [1:0]    warm;

    cau_upper #(.DW(DW), .AW(AW)) u_upper (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .b_re     (b_re),
        .b_im     (b_im),
        .c_re     (c_re),
        .c_im     (c_im),
        .mode     (up_mode),
        .op       (up_op),
        .op2      (up_op2),
        .lo_op    (lo_op),
        .clr      (acc_clear),
        .s1_valid (s1_valid),
        .s1_re    (s1_re),
        .s1_im    (s1_im),
        .s1_lo_op (s1_lo_op),
        .s1_clr   (s1_clr)
    );

    cau_lower #(.AW(AW)) u_lower (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_valid  (s1_valid),
        .u_re      (s1_re),
        .u_im      (s1_im),
        .lo_op     (s1_lo_op),
        .clr       (s1_clr),
        .res_valid (res_valid),
        .res_re    (res_re),
        .res_im    (res_im)
    );

    // Edges-since-reset counter, saturating at two, for the latency check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm <= '0;
        end else if (warm != 2'd2) begin
            warm <= warm + 2'd1;
        end
    end

    // Output valid follows the input valid two edges later.
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2) |-> (res_valid == $past(in_valid, 2)));

endmodule

// File: tb/cau_top_test.sv
`timescale 1ns/1ps
// Self-checking bench: directed corners plus seeded random beats,
// compared against a bench-side reference of the two-stage pipeline.
module cau_top_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [15:0] b_re, b_im, c_re, c_im;
    logic [1:0]  up_mode;
    logic [3:0]  up_op, up_op2;
    logic [1:0]  lo_op;
    logic        acc_clear;
    logic        res_valid;
    logic [39:0] res_re, res_im;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    // Reference pipeline state.
    logic [39:0] m_s1_re = '0, m_s1_im = '0;
    logic [39:0] m_acc_re = '0, m_acc_im = '0;
    logic [39:0] m_out_re = '0, m_out_im = '0;
    logic        m_s1_v = 1'b0, m_out_v = 1'b0;
    int          m_s1_lo = 0;
    bit          m_s1_clr = 0;
    string       m_s1_tag = "", m_out_tag = "";

    always #10 clk = ~clk;

    cau_top #(.DW(16), .AW(40)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .b_re(b_re), .b_im(b_im), .c_re(c_re), .c_im(c_im),
        .up_mode(up_mode), .up_op(up_op), .up_op2(up_op2),
        .lo_op(lo_op), .acc_clear(acc_clear),
        .res_valid(res_valid), .res_re(res_re), .res_im(res_im)
    );

    task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Scalar function of two signed 16-bit values.
    function automatic logic [39:0] fscal(input logic [15:0] a, input logic [15:0] b, input int op);
        longint sa = $signed(a);
        longint sb = $signed(b);
        longint r;
        logic [15:0] w;
        case (op)
            0: r = sa + sb;
            1: r = sa - sb;
            2, 3: r = sa * sb;
            4: r = (sa > sb) ? sa : sb;
            5: r = (sa < sb) ? sa : sb;
            6: r = (sa == sb) ? 1 : 0;
            7: r = (sa < sb) ? 1 : 0;
            8: r = (sa > sb) ? 1 : 0;
            9: r = (sa <= sb) ? 1 : 0;
            10: r = (sa >= sb) ? 1 : 0;
            11, 12, 13, 14: begin
                if (op == 11) w = a & b;
                else if (op == 12) w = ~(a & b);
                else if (op == 13) w = a | b;
                else w = ~(a | b);
                r = $signed(w);
            end
            default: r = sa;
        endcase
        return r[39:0];
    endfunction

    task automatic up_model(input logic [15:0] br, input logic [15:0] bi,
                            input logic [15:0] cr, input logic [15:0] ci,
                            input int mode, input int op, input int op2,
                            output logic [39:0] re, output logic [39:0] im);
        longint sbr = $signed(br), sbi = $signed(bi);
        longint scr = $signed(cr), sci = $signed(ci);
        longint t;
        if (mode == 2) begin
            re = fscal(br, bi, op); im = '0;
        end else if (mode == 1) begin
            re = fscal(br, cr, op); im = fscal(bi, ci, op2);
        end else if (op == 2) begin
            t = sbr * scr - sbi * sci; re = t[39:0];
            t = sbr * sci + sbi * scr; im = t[39:0];
        end else if (op == 3) begin
            t = sbr * scr + sbi * sci; re = t[39:0];
            t = sbi * scr - sbr * sci; im = t[39:0];
        end else if (op == 6) begin
            re = (br == cr && bi == ci) ? 40'd1 : 40'd0; im = '0;
        end else if (op >= 7 && op <= 10) begin
            re = fscal(br, cr, op); im = '0;
        end else begin
            re = fscal(br, cr, op); im = fscal(bi, ci, op);
        end
    endtask

    function automatic logic [39:0] lo_model(input int lo, input bit clr,
                                             input logic [39:0] acc, input logic [39:0] u);
        case (lo)
            1: return clr ? u : acc + u;
            2: return clr ? u : acc - u;
            3: return (clr || $signed(u) > $signed(acc)) ? u : acc;
            default: return acc;
        endcase
    endfunction

    function automatic string tag_of(input int mode, input int op, input int lo, input bit clr);
        string ut, lt;
        if (mode == 2) ut = "R8";
        else if (mode == 1) ut = "R7";
        else if (op == 2 || op == 3) ut = "R4";
        else if (op >= 6 && op <= 10) ut = "R5";
        else if (op >= 11 && op <= 14) ut = "R6";
        else ut = "R3";
        if (lo == 0) lt = "R9";
        else if (clr) lt = "R11";
        else lt = "R10";
        return {ut, "/", lt};
    endfunction

    // One clock: check the outputs, drive a beat, advance the reference by one edge.
    task automatic tick(input bit iv, input logic [15:0] br, input logic [15:0] bi,
                        input logic [15:0] cr, input logic [15:0] ci,
                        input int mode, input int op, input int op2,
                        input int lo, input bit clr);
        logic [39:0] ure, uim;
        @(negedge clk);
        check("R2 res_valid", {39'd0, res_valid}, {39'd0, m_out_v});
        check({m_out_v ? m_out_tag : "R12", " re"}, res_re, m_out_re);
        check({m_out_v ? m_out_tag : "R12", " im"}, res_im, m_out_im);
        in_valid = iv; b_re = br; b_im = bi; c_re = cr; c_im = ci;
        up_mode = mode[1:0]; up_op = op[3:0]; up_op2 = op2[3:0];
        lo_op = lo[1:0]; acc_clear = clr;
        if (m_s1_v) begin
            if (m_s1_lo == 0) begin
                m_out_re = m_s1_re; m_out_im = m_s1_im;
            end else begin
                m_acc_re = lo_model(m_s1_lo, m_s1_clr, m_acc_re, m_s1_re);
                m_acc_im = lo_model(m_s1_lo, m_s1_clr, m_acc_im, m_s1_im);
                m_out_re = m_acc_re; m_out_im = m_acc_im;
            end
            m_out_tag = m_s1_tag;
        end
        m_out_v = m_s1_v;
        m_s1_v = iv;
        if (iv) begin
            up_model(br, bi, cr, ci, mode, op, op2, ure, uim);
            m_s1_re = ure; m_s1_im = uim;
            m_s1_lo = lo; m_s1_clr = clr;
            m_s1_tag = tag_of(mode, op, lo, clr);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 16'h5a5a, 16'ha5a5, 16'h1234, 16'h4321, 0, 2, 0, 1, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #4_000_000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd61803));
        rst_n = 1'b0; in_valid = 1'b1; b_re = 16'h7fff; b_im = 16'h7fff;
        c_re = 16'h7fff; c_im = 16'h7fff; up_mode = 0; up_op = 2; up_op2 = 0;
        lo_op = 1; acc_clear = 0;
        repeat (3) @(negedge clk);
        // R1: reset state at the outputs while reset is still asserted.
        check("R1 res_valid", {39'd0, res_valid}, 40'd0);
        check("R1 res_re", res_re, 40'd0);
        check("R1 res_im", res_im, 40'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        // R1: zero accumulator seen through a first add without clear.
        tick(1, 16'd3, 16'd4, 16'd5, 16'd6, 0, 0, 0, 1, 0);
        // R4 + R10/R11: multiply-accumulate stream, cleared on the first beat.
        for (int i = 0; i < 8; i++)
            tick(1, 16'(i + 1), 16'(-i), 16'(2 * i - 3), 16'(i), 0, 2, 0, 1, i == 0);
        // R4: extreme operands, multiply and conjugate multiply, passed through (R9).
        tick(1, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 0, 2, 0, 0, 0);
        tick(1, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 0, 3, 0, 0, 0);
        tick(1, 16'h8000, 16'h7fff, 16'h7fff, 16'h8000, 0, 3, 0, 0, 0);
        // R5: complex equality needs both parts; ordering on real parts.
        tick(1, 16'd7, 16'd9, 16'd7, 16'd9, 0, 6, 0, 0, 0);
        tick(1, 16'd7, 16'd9, 16'd7, 16'd8, 0, 6, 0, 0, 0);
        tick(1, 16'hfff0, 16'd100, 16'd2, 16'hff00, 0, 7, 0, 0, 0);
        // R6: bitwise logic with sign extension.
        tick(1, 16'hf0f0, 16'h0ff0, 16'h3c3c, 16'h00ff, 0, 12, 0, 0, 0);
        // R7: split with different lane functions.
        tick(1, 16'd100, 16'hff00, 16'd23, 16'd300, 1, 0, 2, 0, 0);
        tick(1, 16'h8000, 16'd5, 16'd1, 16'd5, 1, 4, 6, 0, 0);
        // R8: combine ignores C.
        tick(1, 16'd50, 16'd80, 16'h7fff, 16'h8000, 2, 1, 0, 0, 0);
        tick(1, 16'd50, 16'd80, 16'h0001, 16'h0002, 2, 7, 0, 0, 0);
        // R12: bubbles, then an add shows the accumulator was untouched.
        idle(4);
        tick(1, 16'd1, 16'd1, 16'd1, 16'd0, 0, 0, 0, 1, 0);
        // R9: pass beats between accumulating beats leave the sum alone.
        tick(1, 16'd9, 16'd9, 16'd9, 16'd9, 0, 0, 0, 0, 0);
        tick(1, 16'd1, 16'd0, 16'd0, 16'd0, 0, 0, 0, 1, 0);
        // R11 with subtract and maximum, followed by an accumulating beat.
        tick(1, 16'd10, 16'hfff6, 16'd0, 16'd0, 0, 0, 0, 2, 1);
        tick(1, 16'd3, 16'd3, 16'd0, 16'd0, 0, 0, 0, 2, 0);
        tick(1, 16'hff00, 16'h8000, 16'd0, 16'd0, 0, 0, 0, 3, 1);
        tick(1, 16'hff80, 16'h7fff, 16'd0, 16'd0, 0, 0, 0, 3, 0);
        // R10: accumulator wrap at 40 bits via 2^30 products.
        for (int i = 0; i < 520; i++)
            tick(1, 16'h8000, 16'd0, 16'h8000, 16'd0, 0, 2, 0, 1, i == 0);
        // R2: back-to-back beats and alternating bubbles across random traffic.
        for (int i = 0; i < 3000; i++) begin
            int md = $urandom_range(0, 3);
            int o1 = $urandom_range(0, 15);
            int o2 = $urandom_range(0, 15);
            int lo = $urandom_range(0, 3);
            bit cl = ($urandom_range(0, 7) == 0);
            bit iv = ($urandom_range(0, 3) != 0);
            logic [15:0] r0 = 16'($urandom), r1 = 16'($urandom);
            logic [15:0] r2 = 16'($urandom), r3 = 16'($urandom);
            if ($urandom_range(0, 9) == 0) r2 = r0;
            if ($urandom_range(0, 9) == 0) r3 = r1;
            tick(iv, r0, r1, r2, r3, md, o1, o2, lo, cl);
        end
        idle(4);
        finish_run();
    end

endmodule